// File: doc/BRIEF.md
# Dual Interval Timer

The block holds two independent interval timers behind a small register bus. Each timer owns a 29-bit counter and a 32-bit limit word. A shared prescaler turns the system clock into a one-microsecond tick. A running counter advances once per tick. When the next count would reach the terminal value, the timer raises its own interrupt line. It then either wraps to zero and keeps going (periodic mode) or parks at the terminal value (one-shot mode). The two interrupt lines are meant for two different priority levels. For a rate of F Hz, software writes a terminal value of 1,000,000 / F.

A timer is configured by one write to its limit word, which both sets it up and arms it. The top three bits of that word are flags and the low 29 bits are the terminal value. Bit 31 arms the timer. Bit 30 clears the counter as part of the write. Bit 29 selects periodic mode. Each timer is a small state machine:
- `CH_IDLE`: stopped. Reached from reset, or by a write with bit 31 clear or a zero terminal value.
- `CH_RUN`: counting. Reached by an arming write from any state.
- `CH_HELD`: a one-shot that has expired. Reached from `CH_RUN` when the terminal value is reached with bit 29 clear.

`CH_RUN` stays in `CH_RUN` on an ordinary tick, and also on a wrap when bit 29 is set.

Reading a limit word returns it unchanged and clears that timer's interrupt. Reading a count word returns the live count.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, every register reads as zero, both interrupt lines are low and the read data is zero.
- R2: A counter in `CH_RUN` advances by exactly one per prescaler tick. A tick comes every CLK_HZ/TICK_HZ clock cycles, so a periodic timer with terminal value N fires every N ticks.
- R3: While bit 31 of a limit word is clear, that counter holds its value and its interrupt never fires.
- R4: A limit write with bit 30 set leaves the counter at zero. With bit 30 clear, the counter keeps its previous value.
- R5: With bit 29 set, a counter whose next value reaches the terminal value wraps to zero, stays in `CH_RUN` and fires again on every period.
- R6: With bit 29 clear, the counter fires once, stops at the terminal value in `CH_HELD`, and stays there until its limit word is written again.
- R7: An interrupt is a level that stays high until its limit word is read. A fire in the same cycle as that read wins over the clear.
- R8: A terminal value of zero never arms a timer, so it never fires.
- R9: A count read returns the 29-bit live count with bits 31:29 zero. Writes to count words change nothing.
- R10: Register index 0 is count0, 1 is limit0, 2 is count1 and 3 is limit1. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R11: Timer 0 drives only `irq0` and timer 1 drives only `irq1`. Activity on one timer leaves the other timer's line unchanged.
- R12: When a limit write and a tick land in the same cycle, the write takes effect and that tick does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq0 | output | 1 | Timer 0 interrupt level |
| irq1 | output | 1 | Timer 1 interrupt level |

## Verification
A periodic timer with a short terminal value is used to measure the spacing between rising edges of its interrupt. This separates a counter that steps once per tick from one that steps every cycle, or that misses the wrap. One-shot, disarmed and zero-terminal programming is then applied to the other timer. These cases separate parking at the terminal value from wrapping, and show that the idle timer's line does not move. Finally, limit writes are issued at every phase of the prescaler. A behavioural model compared on every clock then shows whether a write that collides with a tick wins.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int WORD_W      = 32;
    localparam int FLAG_ARM    = 31;
    localparam int FLAG_CLEAR  = 30;
    localparam int FLAG_PERIOD = 29;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_HELD = 2'd2
    } ch_state_e;
endpackage

// File: rtl/dit_tick_gen.sv
module dit_tick_gen #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == LAST);

            // R2: ticks are isolated pulses when dividing
            a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lim_wr,
    input  logic [WORD_W-1:0] lim_wdata,
    input  logic              lim_rd,
    output logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] limit,
    output logic              irq
);
    ch_state_e         state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [WORD_W-1:0] lim_q;
    logic              irq_q;
    logic              fire;
    logic [CNT_W:0]    step;
    logic [CNT_W-1:0]  term;
    logic [CNT_W-1:0]  new_term;

    assign term     = lim_q[CNT_W-1:0];
    assign new_term = lim_wdata[CNT_W-1:0];
    assign step     = {1'b0, count_q} + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            count_q <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (lim_wr) lim_q <= lim_wdata;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        fire    = 1'b0;
        if (lim_wr) begin
            if (lim_wdata[FLAG_CLEAR]) count_d = '0;
            state_d = (lim_wdata[FLAG_ARM] && new_term != '0) ? CH_RUN : CH_IDLE;
        end else begin
            unique case (state_q)
                CH_IDLE: ;
                CH_RUN: begin
                    if (tick) begin
                        if (step >= {1'b0, term}) begin
                            fire = 1'b1;
                            if (lim_q[FLAG_PERIOD]) begin
                                count_d = '0;
                            end else begin
                                count_d = term;
                                state_d = CH_HELD;
                            end
                        end else begin
                            count_d = step[CNT_W-1:0];
                        end
                    end
                end
                CH_HELD: ;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // interrupt output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (fire)   irq_q <= 1'b1;
        else if (lim_rd) irq_q <= 1'b0;
    end

    assign count = count_q;
    assign limit = lim_q;
    assign irq   = irq_q;

    a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !lim_wr) |=> ($stable(count_q) && !$rose(irq_q)));
    a_r8_zero_term_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (term == '0) |-> (state_q != CH_RUN));
    a_r6_held_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HELD && !lim_wr) |=> (state_q == CH_HELD && $stable(count_q)));
    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !lim_rd) |=> irq_q);
    a_r2_no_step_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !lim_wr) |=> $stable(count_q));
    a_r4_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && lim_wdata[FLAG_CLEAR]) |=> (count_q == '0));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int CLK_HZ  = 200_000_000,
    parameter int TICK_HZ = 1_000_000,
    parameter int CNT_W   = 29
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq0,
    output logic        irq1
);
    localparam int NUM_TMR = 2;
    localparam int DIV     = CLK_HZ / TICK_HZ;
    localparam int PAD_W   = WORD_W - CNT_W;

    logic                tick;
    logic [CNT_W-1:0]    cnt_arr [NUM_TMR];
    logic [WORD_W-1:0]   lim_arr [NUM_TMR];
    logic [NUM_TMR-1:0]  irq_vec;
    logic [WORD_W-1:0]   rd_mux;
    logic [WORD_W-1:0]   rdata_q;
    logic                sel_limit;
    logic                sel_tmr;

    assign sel_limit = bus_addr[0];
    assign sel_tmr   = bus_addr[1];

    dit_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
            logic hit;
            assign hit = sel_limit && (sel_tmr == 1'(t));
            dit_channel #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .lim_wr    (bus_wr && hit),
                .lim_wdata (bus_wdata),
                .lim_rd    (bus_rd && hit),
                .count     (cnt_arr[t]),
                .limit     (lim_arr[t]),
                .irq       (irq_vec[t])
            );
        end
    endgenerate

    always_comb begin
        if (sel_limit) rd_mux = lim_arr[sel_tmr];
        else           rd_mux = {{PAD_W{1'b0}}, cnt_arr[sel_tmr]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq0      = irq_vec[0];
    assign irq1      = irq_vec[1];

    a_r9_count_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[0]) |=> (bus_rdata[WORD_W-1:CNT_W] == '0));
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
    localparam int CLK_HZ = 4_000_000;
    localparam int DIV    = 4;
    localparam logic [31:0] ARM = 32'h8000_0000;
    localparam logic [31:0] CLR = 32'h4000_0000;
    localparam logic [31:0] PER = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq0, irq1;

    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    // behavioural reference
    int          m_pre = 0;
    int unsigned m_cnt [2];
    logic [31:0] m_lim [2];
    int          m_st  [2];
    logic        m_irq [2];
    logic [31:0] m_rd = '0;

    always #2.5 clk = ~clk;

    dual_interval_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(1_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq0(irq0), .irq1(irq1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_rd = '0;
            for (int t = 0; t < 2; t++) begin
                m_cnt[t] = 0; m_lim[t] = '0; m_st[t] = 0; m_irq[t] = 1'b0;
            end
        end else begin
            bit tk;
            tk = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            if (bus_rd)
                m_rd = bus_addr[0] ? m_lim[bus_addr[1]] : 32'(m_cnt[bus_addr[1]]);
            for (int t = 0; t < 2; t++) begin
                bit fire, mine;
                int unsigned term;
                fire = 0;
                mine = (bus_addr == 2'(2 * t + 1));
                if (bus_wr && mine) begin
                    m_lim[t] = bus_wdata;
                    if (bus_wdata[30]) m_cnt[t] = 0;
                    m_st[t] = (bus_wdata[31] && bus_wdata[28:0] != 0) ? 1 : 0;
                end else if (tk && m_st[t] == 1) begin
                    term = m_lim[t][28:0];
                    if (m_cnt[t] + 1 >= term) begin
                        fire = 1;
                        if (m_lim[t][29]) m_cnt[t] = 0;
                        else begin m_cnt[t] = term; m_st[t] = 2; end
                    end else m_cnt[t] = m_cnt[t] + 1;
                end
                if (fire) m_irq[t] = 1'b1;
                else if (bus_rd && mine) m_irq[t] = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " irq0"}, {31'b0, irq0}, {31'b0, m_irq[0]});
            chk({cur_req, " irq1"}, {31'b0, irq1}, {31'b0, m_irq[1]});
            chk({cur_req, " rdata"}, bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; #0.1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq0(output int at);
        at = -1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq0) begin at = cyc; break; end
        end
    endtask

    initial begin
        logic [31:0] v;
        int t1, t2;
        idle(3); rst_n = 1'b1;

        // R1 reset state
        idle(1);
        chk("R1 irq0", {31'b0, irq0}, 32'd0);
        chk("R1 irq1", {31'b0, irq1}, 32'd0);
        for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 32'd0); end

        // R5 periodic timer0, terminal 5
        cur_req = "R5";
        wr(2'd1, ARM | CLR | PER | 32'd5);
        wait_irq0(t1);
        chk("R5 first fire", {31'b0, (t1 >= 0)}, 32'd1);
        // R7 level holds without a read
        cur_req = "R7";
        idle(30);
        chk("R7 hold", {31'b0, irq0}, 32'd1);
        rd(2'd1, v);
        chk("R10 limit0 readback", v, ARM | CLR | PER | 32'd5);
        chk("R7 cleared by read", {31'b0, irq0}, 32'd0);

        // R2 period = 5 ticks
        cur_req = "R2";
        wait_irq0(t1); rd(2'd1, v);
        wait_irq0(t2); rd(2'd1, v);
        chk("R2 period cycles", 32'(t2 - t1), 32'(5 * DIV));
        chk("R5 refire", {31'b0, (t2 >= 0)}, 32'd1);

        // R9 count reads and ignored count writes
        cur_req = "R9";
        rd(2'd0, v);
        chk("R9 pad bits", {29'b0, v[31:29]}, 32'd0);
        chk("R9 in range", {31'b0, (v < 5)}, 32'd1);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, v);
        chk("R9 count1 unwritten", v, 32'd0);

        // disarm timer0, clear its irq
        cur_req = "R11";
        wr(2'd1, 32'd0);
        rd(2'd1, v);
        idle(2);
        chk("R11 irq0 low", {31'b0, irq0}, 32'd0);

        // R6 one-shot timer1, terminal 3
        cur_req = "R6";
        wr(2'd3, ARM | CLR | 32'd3);
        idle(60);
        rd(2'd2, v);
        chk("R6 parked at term", v, 32'd3);
        chk("R6 irq1 set", {31'b0, irq1}, 32'd1);
        chk("R11 irq0 untouched", {31'b0, irq0}, 32'd0);
        idle(40);
        rd(2'd2, v);
        chk("R6 still parked", v, 32'd3);

        // R4 and R3: writes without arm
        cur_req = "R4";
        wr(2'd3, 32'd10);
        rd(2'd2, v);
        chk("R4 count kept", v, 32'd3);
        wr(2'd3, CLR | 32'd10);
        rd(2'd2, v);
        chk("R4 count cleared", v, 32'd0);
        cur_req = "R3";
        rd(2'd3, v);
        idle(60);
        rd(2'd2, v);
        chk("R3 disarmed frozen", v, 32'd0);
        chk("R3 no irq", {31'b0, irq1}, 32'd0);

        // R8 zero terminal
        cur_req = "R8";
        wr(2'd3, ARM | CLR | PER);
        idle(60);
        chk("R8 never fires", {31'b0, irq1}, 32'd0);
        rd(2'd2, v);
        chk("R8 count idle", v, 32'd0);

        // R12 writes at every prescaler phase
        cur_req = "R12";
        for (int p = 0; p < 2 * DIV; p++) begin
            wr(2'd1, ARM | PER | 32'd7);
            idle(p);
            rd(2'd0, v);
            rd(2'd1, v);
        end
        idle(40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule